// File: doc/BRIEF.md
# Power Button Debounce and Interrupt

This block conditions the power-on pin of a power-management controller. A configuration input selects one of two meanings for that pin. In level mode, the pin acts as an active-high enable: the pin being high asks the controller to power up. In button mode, the pin is wired to a mechanical push-button that idles high. Pressing the button pulls the pin low, and that debounced press asks the controller to power up. In both modes no power-up request leaves the block while the supply-valid flag is low.

The pin passes through a two-flop synchronizer and then through one debouncer. The debouncer measures each candidate level in whole ticks of a millisecond enable. A press, seen as a falling edge, needs a window picked by a 2-bit selector. A release, seen as a rising edge, always needs the base window. A glitch that ends before its window runs out restarts the count and produces no edge.

The block has four outputs. The sense output shows the synchronized pin. The interrupt output is sticky: in button mode it is set by each debounced press and each debounced release. It stays set until a software clear or an off-mode clear arrives. The long-press output rises once the button has stayed debounced-low for a long hold time.

Top module: `pwron_conditioner`

## Requirements
- R1: `sense` equals `pin_raw` delayed by two clock edges. It reads 1 while reset is held.
- R2: In level mode (`mode_button`=0), `turn_on_req` is 1 exactly when the synchronized pin and `supply_ok` were both 1 on the previous edge. It therefore lags `pin_raw` by three edges.
- R3: In button mode (`mode_button`=1), `turn_on_req` is a single-cycle pulse. It goes high on the edge after a debounced press (falling edge), and a debounced release never raises it.
- R4: While `supply_ok` is 0, `turn_on_req` stays 0 on the next edge, in either mode.
- R5: A debounced press needs the synchronized pin to differ from the debounced level for a number of `tick_ms` ticks set by `fall_sel`. Codes 0 and 1 select FALL_BASE_T ticks, code 2 selects FALL_MID_T ticks and code 3 selects FALL_LONG_T ticks. One tick fewer produces no press.
- R6: A debounced release always needs exactly RISE_T ticks, whatever the value of `fall_sel`.
- R7: If the pin returns to the debounced level before its window completes, the count restarts from zero and no edge is produced.
- R8: In button mode, `irq` becomes 1 on the edge after any debounced press or release. In level mode, debounced edges leave `irq` unchanged.
- R9: Once set, `irq` stays 1 until `sw_clear` or `off_clear` is sampled high. It then reads 0 after that edge, unless a new edge arrives on the same edge, in which case the set wins.
- R10: In button mode, `long_press` rises after HOLD_T ticks counted from the debounced press. It falls on the edge after the debounced release, or when the block leaves button mode.
- R11: After reset, `irq`, `turn_on_req` and `long_press` are 0, and the debounced level is high (button released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond enable |
| pin_raw | input | 1 | Asynchronous power-on pin |
| mode_button | input | 1 | 0 = level enable, 1 = push-button |
| fall_sel | input | 2 | Press (falling-edge) debounce selector |
| supply_ok | input | 1 | Input supply above undervoltage threshold |
| sw_clear | input | 1 | Software clear of the interrupt |
| off_clear | input | 1 | Clear on passing through off mode |
| sense | output | 1 | Synchronized real-time pin level |
| irq | output | 1 | Sticky interrupt on debounced edges |
| turn_on_req | output | 1 | Power-up request |
| long_press | output | 1 | Button held beyond the hold time |

## Verification
The bench builds the block with RISE_T=3, FALL_BASE_T=3, FALL_MID_T=5, FALL_LONG_T=8 and HOLD_T=12, in place of the millisecond-scale defaults. With these windows the bench can test every `fall_sel` code at its exact boundary, one tick short and one tick full, together with a release under each code. The short hold time also lets the bench cover the whole long-press cycle, from press through assertion to release, in a few hundred clock cycles. Tests of glitch restart, supply gating and level-mode behaviour run on the same small configuration.

// File: rtl/pwron_pkg.sv
package pwron_pkg;

    typedef enum logic {
        MODE_LEVEL  = 1'b0,
        MODE_BUTTON = 1'b1
    } pwron_mode_e;

    typedef struct packed {
        logic level;
        logic fell;
        logic rose;
    } deb_out_t;

    function automatic int unsigned pick_fall_window(input logic [1:0] sel,
                                                     input int unsigned base_t,
                                                     input int unsigned mid_t,
                                                     input int unsigned long_t);
        case (sel)
            2'b10:   return mid_t;
            2'b11:   return long_t;
            default: return base_t;
        endcase
    endfunction

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwron_sync.sv
module pwron_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pwron_debounce.sv
module pwron_debounce
    import pwron_pkg::*;
#(
    parameter int unsigned RISE_T      = 30,
    parameter int unsigned FALL_BASE_T = 30,
    parameter int unsigned FALL_MID_T  = 120,
    parameter int unsigned FALL_LONG_T = 750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       din,
    input  logic [1:0] fall_sel,
    output deb_out_t   q
);
    localparam int unsigned MAXW = max_of3(RISE_T, FALL_BASE_T, max_of3(FALL_MID_T, FALL_LONG_T, 1));
    localparam int unsigned CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] win_m1;
    logic          level, fell_q, rose_q;

    always_comb begin
        if (level) win_m1 = CW'(pick_fall_window(fall_sel, FALL_BASE_T, FALL_MID_T, FALL_LONG_T) - 1);
        else       win_m1 = CW'(RISE_T - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= 1'b1;
            cnt    <= '0;
            fell_q <= 1'b0;
            rose_q <= 1'b0;
        end else begin
            fell_q <= 1'b0;
            rose_q <= 1'b0;
            if (din == level) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt >= win_m1) begin
                    level  <= din;
                    cnt    <= '0;
                    fell_q <= level;
                    rose_q <= ~level;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign q = '{level: level, fell: fell_q, rose: rose_q};
endmodule

// File: rtl/pwron_hold_timer.sv
module pwron_hold_timer #(
    parameter int unsigned HOLD_T = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enable,
    output logic done
);
    localparam int unsigned HW = $clog2(HOLD_T + 1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable)                   cnt <= '0;
        else if (tick && cnt != HW'(HOLD_T))  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == HW'(HOLD_T));
endmodule

// File: rtl/pwron_conditioner.sv
module pwron_conditioner
    import pwron_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RISE_T      = 30,
    parameter int unsigned FALL_BASE_T = 30,
    parameter int unsigned FALL_MID_T  = 120,
    parameter int unsigned FALL_LONG_T = 750,
    parameter int unsigned HOLD_T      = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic       pin_raw,
    input  logic       mode_button,
    input  logic [1:0] fall_sel,
    input  logic       supply_ok,
    input  logic       sw_clear,
    input  logic       off_clear,
    output logic       sense,
    output logic       irq,
    output logic       turn_on_req,
    output logic       long_press
);
    pwron_mode_e mode;
    logic        pin_s;
    deb_out_t    deb;
    logic        hold_done;
    logic        edge_hit;

    assign mode = pwron_mode_e'(mode_button);

    pwron_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
    );

    pwron_debounce #(
        .RISE_T(RISE_T), .FALL_BASE_T(FALL_BASE_T),
        .FALL_MID_T(FALL_MID_T), .FALL_LONG_T(FALL_LONG_T)
    ) u_deb (
        .clk(clk), .rst(rst), .tick(tick_ms), .din(pin_s),
        .fall_sel(fall_sel), .q(deb)
    );

    pwron_hold_timer #(.HOLD_T(HOLD_T)) u_hold (
        .clk(clk), .rst(rst), .tick(tick_ms),
        .enable((mode == MODE_BUTTON) && !deb.level),
        .done(hold_done)
    );

    assign edge_hit = (mode == MODE_BUTTON) && (deb.fell || deb.rose);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq         <= 1'b0;
            turn_on_req <= 1'b0;
        end else begin
            if (edge_hit)                    irq <= 1'b1;
            else if (sw_clear || off_clear)  irq <= 1'b0;

            if (mode == MODE_BUTTON) turn_on_req <= supply_ok && deb.fell;
            else                     turn_on_req <= supply_ok && pin_s;
        end
    end

    assign sense      = pin_s;
    assign long_press = hold_done && (mode == MODE_BUTTON);
endmodule

// File: rtl/pwron_conditioner_chk.sv
module pwron_conditioner_chk (
    input logic clk,
    input logic rst,
    input logic mode_button,
    input logic supply_ok,
    input logic sw_clear,
    input logic off_clear,
    input logic irq,
    input logic turn_on_req
);
    // R3: a press request in button mode lasts one cycle
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (turn_on_req && mode_button) |=> !(turn_on_req && mode_button));

    // R4: no request follows a cycle without a valid supply
    p_supply_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !turn_on_req);

    // R9: interrupt holds without a clear
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !sw_clear && !off_clear) |=> irq);

    // R9: interrupt only drops after a clear
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(sw_clear || off_clear));

    // R8: interrupt only rises from button mode
    p_irq_mode_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mode_button));
endmodule

bind pwron_conditioner pwron_conditioner_chk i_chk (
    .clk(clk), .rst(rst), .mode_button(mode_button), .supply_ok(supply_ok),
    .sw_clear(sw_clear), .off_clear(off_clear), .irq(irq), .turn_on_req(turn_on_req)
);

// File: tb/test_pwron_conditioner.sv
`timescale 1ns/1ps
module test_pwron_conditioner;
    localparam int unsigned RT = 3, FB = 3, FM = 5, FL = 8, HT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b0, pin_raw = 1'b1, mode_button = 1'b1;
    logic [1:0] fall_sel = 2'd0;
    logic       supply_ok = 1'b1, sw_clear = 1'b0, off_clear = 1'b0;
    logic       sense, irq, turn_on_req, long_press;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwron_conditioner #(
        .RISE_T(RT), .FALL_BASE_T(FB), .FALL_MID_T(FM), .FALL_LONG_T(FL), .HOLD_T(HT)
    ) i_pwron_conditioner (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .pin_raw(pin_raw),
        .mode_button(mode_button), .fall_sel(fall_sel), .supply_ok(supply_ok),
        .sw_clear(sw_clear), .off_clear(off_clear), .sense(sense), .irq(irq),
        .turn_on_req(turn_on_req), .long_press(long_press)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_pin(input logic v);
        pin_raw = v;
        cycles(3);
    endtask

    task automatic clear_irq();
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
        @(negedge clk);
    endtask

    function automatic int fall_win(input int sel);
        return (sel < 2) ? FB : ((sel == 2) ? FM : FL);
    endfunction

    initial begin
        cycles(3);
        // R11 / R1: reset state
        check("R11 irq after reset", irq, 1'b0);
        check("R11 long_press after reset", long_press, 1'b0);
        check("R1 sense during reset", sense, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R11 turn_on_req after reset", turn_on_req, 1'b0);

        // R1: two-edge latency on sense
        pin_raw = 1'b0;
        @(negedge clk);
        check("R1 sense after one edge", sense, 1'b1);
        @(negedge clk);
        check("R1 sense after two edges", sense, 1'b0);
        set_pin(1'b1);

        // R5 / R6 / R3 / R8 / R9: sweep every selector code
        for (int sel = 0; sel < 4; sel++) begin
            fall_sel = 2'(sel);
            set_pin(1'b0);
            run_ticks(fall_win(sel) - 1);
            check($sformatf("R5 no press one tick short sel=%0d", sel), irq, 1'b0);
            run_ticks(1);
            check($sformatf("R5 press at window sel=%0d", sel), irq, 1'b1);
            check($sformatf("R3 request pulse sel=%0d", sel), turn_on_req, 1'b1);
            @(negedge clk);
            check($sformatf("R3 request one cycle sel=%0d", sel), turn_on_req, 1'b0);
            clear_irq();
            check($sformatf("R9 sw_clear sel=%0d", sel), irq, 1'b0);
            set_pin(1'b1);
            run_ticks(RT - 1);
            check($sformatf("R6 no release one tick short sel=%0d", sel), irq, 1'b0);
            run_ticks(1);
            check($sformatf("R6 R8 release irq sel=%0d", sel), irq, 1'b1);
            check($sformatf("R3 no request on release sel=%0d", sel), turn_on_req, 1'b0);
            clear_irq();
        end

        // R7: glitch restarts the count
        fall_sel = 2'd0;
        set_pin(1'b0);
        run_ticks(FB - 1);
        set_pin(1'b1);
        set_pin(1'b0);
        run_ticks(FB - 1);
        check("R7 restarted count no edge", irq, 1'b0);
        run_ticks(1);
        check("R7 full window after restart", irq, 1'b1);

        // R9: sticky, then off_clear
        cycles(10);
        check("R9 irq holds", irq, 1'b1);
        off_clear = 1'b1;
        @(negedge clk);
        off_clear = 1'b0;
        check("R9 off_clear", irq, 1'b0);
        set_pin(1'b1);
        run_ticks(RT);
        clear_irq();

        // R4: supply gating in button mode
        supply_ok = 1'b0;
        set_pin(1'b0);
        run_ticks(FB);
        check("R4 press without supply no request", turn_on_req, 1'b0);
        check("R8 press still sets irq", irq, 1'b1);
        set_pin(1'b1);
        run_ticks(RT);
        clear_irq();

        // R2 / R4: level mode
        mode_button = 1'b0;
        cycles(2);
        check("R4 level high without supply", turn_on_req, 1'b0);
        supply_ok = 1'b1;
        cycles(2);
        check("R2 level high with supply", turn_on_req, 1'b1);
        pin_raw = 1'b0;
        cycles(2);
        check("R2 request still high before latency", turn_on_req, 1'b1);
        @(negedge clk);
        check("R2 request low after three edges", turn_on_req, 1'b0);
        run_ticks(FB);
        check("R8 level press leaves irq", irq, 1'b0);
        set_pin(1'b1);
        run_ticks(RT);
        check("R8 level release leaves irq", irq, 1'b0);
        check("R2 level high again", turn_on_req, 1'b1);

        // R10: long press
        mode_button = 1'b1;
        cycles(2);
        set_pin(1'b0);
        run_ticks(FB);
        run_ticks(HT - 1);
        check("R10 no long press one tick short", long_press, 1'b0);
        run_ticks(1);
        check("R10 long press asserted", long_press, 1'b1);
        run_ticks(4);
        check("R10 long press holds", long_press, 1'b1);
        set_pin(1'b1);
        check("R10 held until debounced release", long_press, 1'b1);
        run_ticks(RT);
        check("R10 dropped after release", long_press, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule